// File: doc/BRIEF.md
# Decoder Control and Status Port over I2C

This block is a two-wire bus slave that gives a host processor access to the settings of a sound decoder and lets it read back what the decoder has found. Three writable registers hold the output-routing and mute controls and the two error-count thresholds used by automatic muting; their contents leave the block as parallel ports, and one control bit drives a general-purpose output pin on its own.

Reads are different from writes: they take no register pointer. Every read transfer streams a fixed sequence of four bytes (a status byte, the error count, and two bytes of side-channel data with their status flags) and wraps back to the status byte if the host keeps acknowledging. Some status flags are sticky and are cleared by the act of reading the byte that carries them, so the host sees every event exactly once.

The bus lines are sampled by a system clock at least ten times faster than the bus clock; START, STOP and clock edges are found in that clock domain, and the data line is driven through an open-drain enable.

Top module: `ctl_i2c_slave`

## Requirements
- R1: After reset the control register reads 0x90, the upper limit 0x50, the lower limit 0x14, the pin output is low and the data line is released.
- R2: The block acknowledges only the 7-bit address 101101X, X being the level of `addr_sel` (address byte 0xB6/0xB7 when high, 0xB4/0xB5 when low); any other address, the general call 0x00 included, gets no acknowledge and changes nothing.
- R3: In a write, the first byte after the address is a register pointer (0 control, 1 upper limit, 2 lower limit, 3 treated as 0); each following byte is stored at the pointer, which then steps 0, 1, 2 and wraps from 2 to 0.
- R4: `port2_o` follows bit 2 of the control register.
- R5: A read returns, in order, the status byte {PONRES, `dec_stat[5:0]`, CFC}, `err_cnt`, the stored side-channel bits [7:0], then {OVW, SAD, 0, `ci_bits[1:0]`, side-channel bits [10:8]}, and wraps to the status byte after the fourth.
- R6: PONRES (status bit 7) is 1 after reset and is cleared once a status byte transfer finishes its ninth clock.
- R7: A `cfg_chg` pulse sets CFC (status bit 0); it is cleared once a status byte transfer finishes its ninth clock.
- R8: An `ad_strobe` pulse stores `ad_bits` and sets SAD; a strobe while SAD is already set also sets OVW; both clear once the fourth read byte finishes its ninth clock.
- R9: When the host answers a read byte with no acknowledge, the block releases the data line and sends nothing more until the next START; the clear-on-read action of that byte still happens.
- R10: The block changes its data-line drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 10x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | When high, pull the data line low |
| addr_sel | input | 1 | Selects the low address bit |
| dec_stat | input | 6 | Live decoder status flags for the status byte |
| cfg_chg | input | 1 | One-cycle pulse: configuration changed |
| err_cnt | input | 8 | Current error count |
| ad_bits | input | 11 | New side-channel data bits |
| ad_strobe | input | 1 | One-cycle pulse: store `ad_bits` |
| ci_bits | input | 2 | Live control-information bits |
| ctl_o | output | 8 | Control register |
| emax_o | output | 8 | Upper error limit register |
| emin_o | output | 8 | Lower error limit register |
| port2_o | output | 1 | General-purpose pin output |

## Verification
The assertions watch on every cycle that the data-line drive never moves while SCL is high, that registers change only in the cycle an acknowledge is being driven, that an address acknowledge starts only on a matching address, and that the SAD, OVW and CFC flags set on their pulses with OVW never standing without SAD. The read order, the exact moments of the clear-on-read actions, pointer wrap, address selection and behaviour after a refused byte only show up in the bench's bus transactions, where every byte received is compared against a queue of expected bytes.

// File: rtl/ctl_i2c_slave.sv
module ctl_i2c_slave #(
  parameter logic [5:0] ADDR_HI  = 6'b101101,
  parameter logic [7:0] CTL_RST  = 8'h90,
  parameter logic [7:0] EMAX_RST = 8'h50,
  parameter logic [7:0] EMIN_RST = 8'h14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic        addr_sel,
  input  logic [5:0]  dec_stat,
  input  logic        cfg_chg,
  input  logic [7:0]  err_cnt,
  input  logic [10:0] ad_bits,
  input  logic        ad_strobe,
  input  logic [1:0]  ci_bits,
  output logic [7:0]  ctl_o,
  output logic [7:0]  emax_o,
  output logic [7:0]  emin_o,
  output logic        port2_o
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WR, S_WACK, S_RD, S_RACK} st_t;

  st_t         state;
  logic [1:0]  scl_sy, sda_sy;
  logic        scl_q, sda_q;
  logic [3:0]  cnt;
  logic [7:0]  sr;
  logic        rw, first, mack;
  logic [1:0]  ptr, idx;
  logic        ponres, cfc, sad, ovw;
  logic [10:0] ad_reg;
  logic [7:0]  rd_bytes [4];

  wire scl_s     = scl_sy[1];
  wire sda_s     = sda_sy[1];
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire start_c   = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c    = scl_s & scl_q & ~sda_q & sda_s;
  wire [1:0] nidx = idx + 2'd1;
  wire rack_end  = (state == S_RACK) && scl_fall && !start_c && !stop_c;
  wire clr_stat  = rack_end && (idx == 2'd0);
  wire clr_ad    = rack_end && (idx == 2'd3);
  wire in_aack   = (state == S_AACK);

  assign port2_o = ctl_o[2];

  always_comb begin
    rd_bytes[0] = {ponres, dec_stat, cfc};
    rd_bytes[1] = err_cnt;
    rd_bytes[2] = ad_reg[7:0];
    rd_bytes[3] = {ovw, sad, 1'b0, ci_bits, ad_reg[10:8]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ponres <= 1'b1;
      cfc    <= 1'b0;
      sad    <= 1'b0;
      ovw    <= 1'b0;
      ad_reg <= '0;
    end else begin
      if (clr_stat) begin
        ponres <= 1'b0;
        cfc    <= 1'b0;
      end
      if (cfg_chg) cfc <= 1'b1;
      if (clr_ad) begin
        sad <= 1'b0;
        ovw <= 1'b0;
      end
      if (ad_strobe) begin
        ad_reg <= ad_bits;
        sad    <= 1'b1;
        ovw    <= (sad | ovw) & ~clr_ad;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      sr     <= '0;
      sda_oe <= 1'b0;
      rw     <= 1'b0;
      first  <= 1'b0;
      mack   <= 1'b0;
      ptr    <= '0;
      idx    <= '0;
      ctl_o  <= CTL_RST;
      emax_o <= EMAX_RST;
      emin_o <= EMIN_RST;
    end else if (start_c) begin
      state  <= S_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      state  <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        S_ADDR: begin
          if (scl_rise) begin
            sr  <= {sr[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            if (sr[7:1] == {ADDR_HI, addr_sel}) begin
              state  <= S_AACK;
              sda_oe <= 1'b1;
              rw     <= sr[0];
              idx    <= '0;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        S_AACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              state  <= S_RD;
              sr     <= rd_bytes[0];
              sda_oe <= ~rd_bytes[0][7];
            end else begin
              state  <= S_WR;
              sda_oe <= 1'b0;
              first  <= 1'b1;
            end
          end
        end
        S_WR: begin
          if (scl_rise) begin
            sr  <= {sr[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            state  <= S_WACK;
            sda_oe <= 1'b1;
            if (first) begin
              ptr   <= (sr[1:0] == 2'd3) ? 2'd0 : sr[1:0];
              first <= 1'b0;
            end else begin
              case (ptr)
                2'd1:    emax_o <= sr;
                2'd2:    emin_o <= sr;
                default: ctl_o  <= sr;
              endcase
              ptr <= (ptr == 2'd2) ? 2'd0 : ptr + 2'd1;
            end
          end
        end
        S_WACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            state  <= S_WR;
          end
        end
        S_RD: begin
          if (scl_fall) begin
            if (cnt == 4'd7) begin
              sda_oe <= 1'b0;
              state  <= S_RACK;
            end else begin
              sr     <= {sr[6:0], 1'b0};
              sda_oe <= ~sr[6];
              cnt    <= cnt + 4'd1;
            end
          end
        end
        S_RACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              idx    <= nidx;
              sr     <= rd_bytes[nidx];
              sda_oe <= ~rd_bytes[nidx][7];
              cnt    <= '0;
              state  <= S_RD;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ctl_i2c_slave_chk.sv
module ctl_i2c_slave_chk #(
  parameter logic [5:0] ADDR_HI = 6'b101101
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       addr_sel,
  input logic       cfg_chg,
  input logic       ad_strobe,
  input logic [7:0] ctl_o,
  input logic [7:0] emax_o,
  input logic [7:0] emin_o,
  input logic       cfc,
  input logic       sad,
  input logic       ovw,
  input logic       in_aack,
  input logic [7:0] sr
);

  AST_RESET_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ctl_o == 8'h90 && emax_o == 8'h50 && emin_o == 8'h14)); // R1

  AST_ACK_ONLY_OWN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && in_aack) |-> (sr[7:1] == {ADDR_HI, addr_sel})); // R2

  AST_REG_WRITE_AT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ctl_o) || !$stable(emax_o) || !$stable(emin_o)) |-> sda_oe); // R3

  AST_CFC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> cfc); // R7

  AST_SAD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ad_strobe |=> sad); // R8

  AST_OVW_IMPLIES_SAD: assert property (@(posedge clk) disable iff (!rst_n)
    ovw |-> sad); // R8

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i); // R10

endmodule

bind ctl_i2c_slave ctl_i2c_slave_chk #(.ADDR_HI(ADDR_HI)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .addr_sel(addr_sel),
  .cfg_chg(cfg_chg), .ad_strobe(ad_strobe), .ctl_o(ctl_o), .emax_o(emax_o),
  .emin_o(emin_o), .cfc(cfc), .sad(sad), .ovw(ovw), .in_aack(in_aack), .sr(sr)
);

// File: tb/test_ctl_i2c_slave.sv
module test_ctl_i2c_slave;
  localparam int Q = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, addr_sel = 1'b1;
  logic        cfg_chg = 1'b0, ad_strobe = 1'b0;
  logic [5:0]  dec_stat = '0;
  logic [7:0]  err_cnt = '0;
  logic [10:0] ad_bits = '0;
  logic [1:0]  ci_bits = '0;
  logic        sda_oe, port2_o;
  logic [7:0]  ctl_o, emax_o, emin_o;
  wire         sda_line = sda_m & ~sda_oe;

  ctl_i2c_slave i_ctl_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .dec_stat(dec_stat), .cfg_chg(cfg_chg), .err_cnt(err_cnt),
    .ad_bits(ad_bits), .ad_strobe(ad_strobe), .ci_bits(ci_bits),
    .ctl_o(ctl_o), .emax_o(emax_o), .emin_o(emin_o), .port2_o(port2_o)
  );

  int n_chk = 0, n_fail = 0, viol = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] obs;
  event       obs_ev;

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_byte(input logic [7:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic bus_bit(input logic b, output logic r);
    sda_m = b; tick(Q);
    scl = 1'b1; tick(Q);
    r = sda_line; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], r);
    bus_bit(1'b1, r);
    ack = !r;
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, r);
      v[i] = r;
    end
    bus_bit(!give_ack, r);
  endtask

  task automatic wr_txn(input logic [7:0] dev, input logic exp_ack, input int n,
                        input logic [7:0] d[5], input string req);
    logic ack;
    bus_start();
    wr_byte(dev, ack);
    chk(req, ack, exp_ack);
    if (ack) for (int i = 0; i < n; i++) begin
      wr_byte(d[i], ack);
      chk(req, ack, 1'b1);
    end
    bus_stop();
  endtask

  task automatic rd_txn(input int n);
    logic ack;
    logic [7:0] v;
    bus_start();
    wr_byte({6'b101101, addr_sel, 1'b1}, ack);
    chk("R2 read address ack", ack, 1'b1);
    for (int i = 0; i < n; i++) begin
      rd_byte(i != n - 1, v);
      obs = v;
      ->obs_ev;
    end
    chk("R9 data line released after refused byte", sda_oe, 1'b0);
    bus_stop();
  endtask

  task automatic pulse_cfg();
    cfg_chg = 1'b1; tick(1); cfg_chg = 1'b0; tick(1);
  endtask

  task automatic pulse_ad(input logic [10:0] v);
    ad_bits = v; ad_strobe = 1'b1; tick(1); ad_strobe = 1'b0; tick(1);
  endtask

  initial begin
    forever begin
      @(obs_ev);
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R5: actual %0h expected no byte", obs);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (obs !== e) begin
          n_fail++;
          $display("FAIL %s: actual %0h expected %0h", t, obs, e);
        end
      end
    end
  end

  logic prev_scl = 1'b1, prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && prev_scl && scl && (sda_oe !== prev_oe)) viol++;
    prev_scl <= scl;
    prev_oe  <= sda_oe;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    chk("R1 ctl reset", ctl_o, 8'h90);
    chk("R1 emax reset", emax_o, 8'h50);
    chk("R1 emin reset", emin_o, 8'h14);
    chk("R1 pin reset", port2_o, 1'b0);
    chk("R1 data line released", sda_oe, 1'b0);

    wr_txn(8'hB4, 1'b0, 0, '{8'h0, 8'h0, 8'h0, 8'h0, 8'h0}, "R2 other select level refused");
    wr_txn(8'h00, 1'b0, 0, '{8'h0, 8'h0, 8'h0, 8'h0, 8'h0}, "R2 general call refused");
    wr_txn(8'h5A, 1'b0, 0, '{8'h0, 8'h0, 8'h0, 8'h0, 8'h0}, "R2 foreign address refused");
    chk("R2 ctl untouched", ctl_o, 8'h90);

    wr_txn(8'hB6, 1'b1, 5, '{8'h00, 8'hA5, 8'h3C, 8'h07, 8'h11}, "R3 stream write ack");
    chk("R3 wrap to ctl", ctl_o, 8'h11);
    chk("R3 emax", emax_o, 8'h3C);
    chk("R3 emin", emin_o, 8'h07);
    chk("R4 pin low", port2_o, 1'b0);

    wr_txn(8'hB6, 1'b1, 2, '{8'h03, 8'h66, 8'h0, 8'h0, 8'h0}, "R3 pointer 3 write ack");
    chk("R3 pointer 3 selects ctl", ctl_o, 8'h66);
    chk("R4 pin high", port2_o, 1'b1);
    wr_txn(8'hB6, 1'b1, 2, '{8'h00, 8'hFB, 8'h0, 8'h0, 8'h0}, "R4 write ack");
    chk("R4 pin low again", port2_o, 1'b0);

    addr_sel = 1'b0;
    tick(2);
    wr_txn(8'hB6, 1'b0, 0, '{8'h0, 8'h0, 8'h0, 8'h0, 8'h0}, "R2 high select refused when low");
    wr_txn(8'hB4, 1'b1, 2, '{8'h02, 8'h99, 8'h0, 8'h0, 8'h0}, "R2 low select ack");
    chk("R2 R3 emin via low select", emin_o, 8'h99);
    chk("R3 emax untouched", emax_o, 8'h3C);
    addr_sel = 1'b1;
    tick(2);

    dec_stat = 6'b101101;
    err_cnt  = 8'h5E;
    ci_bits  = 2'b10;
    pulse_ad(11'h5A3);
    pulse_cfg();
    expect_byte(8'hDB, "R5 R6 R7 status with flags");
    expect_byte(8'h5E, "R5 error count");
    expect_byte(8'hA3, "R5 side data low");
    expect_byte(8'h55, "R5 R8 side data high with SAD");
    rd_txn(4);
    expect_byte(8'h5A, "R6 R7 flags cleared");
    rd_txn(1);
    expect_byte(8'h5A, "R5 status");
    expect_byte(8'h5E, "R5 error count");
    expect_byte(8'hA3, "R5 side data low kept");
    expect_byte(8'h15, "R8 SAD cleared");
    rd_txn(4);

    ci_bits = 2'b01;
    pulse_ad(11'h7FF);
    pulse_ad(11'h001);
    expect_byte(8'h5A, "R5 status");
    expect_byte(8'h5E, "R5 error count");
    expect_byte(8'h01, "R8 latest side data low");
    expect_byte(8'hC8, "R8 overwrite flag");
    expect_byte(8'h5A, "R5 wrap to status");
    rd_txn(5);

    pulse_cfg();
    expect_byte(8'h5B, "R7 CFC set");
    rd_txn(1);
    expect_byte(8'h5A, "R9 clear after refused status byte");
    expect_byte(8'h5E, "R9 error count then refuse");
    rd_txn(2);

    tick(20);
    chk("R5 expected queue drained", exp_q.size(), 0);
    chk("R10 drive stable while SCL high", viol, 0);
    done = 1;
    report();
  end
endmodule